// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which interrupt an 8-bit processor core takes next. It has five request inputs. One is a non-maskable request. Three are restart requests, and each of these carries a fixed vector. The last is a general request, whose service instruction comes from outside. The block holds three per-level mask bits and a global enable flag. The core updates them through a small command port. Requests are evaluated only at the decision point the core marks near the end of each instruction, or on every cycle while the core sits in a hold or halted state.

When a request wins, the block reports it one clock later. It gives the fixed restart address or, for the general request, a flag telling the core to hold its program counter and run an acknowledge cycle. The core's next read strobe is then steered onto a separate acknowledge output so that external logic can place an instruction on the bus. Any acceptance made while the core is idle also raises a wake pulse that takes the core out of power-down. Every acceptance clears the global enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A non-maskable request is accepted whatever the mask bits and the global enable say, and it reports vector 0x0024.
- R2: Fixed priority, highest first: non-maskable (0x0024), edge restart (0x003C), high restart (0x0034), low restart (0x002C), general request. `take_o` pulses for one cycle in the clock after the decision edge, with the winner's vector on `vec_o`.
- R3: A command write with `cmd_data_i[3]`=1 loads the masks from `cmd_data_i[2:0]`: bit0 is the low restart, bit1 the high restart, bit2 the edge restart, and 1 means masked. With bit3=0 the masks are unchanged. `cmd_data_i[4]`=1 clears the edge-restart latch.
- R4: Requests are evaluated only at a clock edge where `sample_i` or `idle_i` is high.
- R5: The global enable is 0 after reset. `en_set_i` sets it and `en_clr_i` clears it. Every acceptance clears it, and a clear wins over a set in the same cycle. When it is 0, no request except the non-maskable one is accepted.
- R6: Reset sets all three mask bits and clears the edge-restart latch. `take_o`, `wake_o`, `intr_ack_o`, `rd_o` and `inta_o` are all 0.
- R7: The edge restart is captured on a rising edge and stays pending, even while masked, until it is serviced or cleared by command. The high and low restarts are level-sensitive.
- R8: The non-maskable request needs a rising edge and a high level at the decision edge. Once accepted, it is not accepted again until the input has returned low.
- R9: `wake_o` pulses together with `take_o` when the acceptance happened while `idle_i` was high, and only then.
- R10: Accepting the general request sets `intr_ack_o` with `vec_o`=0. The next read strobe from `rd_req_i` appears on `inta_o` instead of `rd_o`. Later reads go to `rd_o` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 1 | Decision point of the current instruction |
| idle_i | input | 1 | Core is in hold or halt; evaluate every cycle |
| nmi_i | input | 1 | Non-maskable request |
| rq_edge_i | input | 1 | Edge-captured restart request |
| rq_hi_i | input | 1 | High level-sensitive restart request |
| rq_lo_i | input | 1 | Low level-sensitive restart request |
| gen_irq_i | input | 1 | General request serviced via acknowledge cycle |
| cmd_we_i | input | 1 | Mask command write strobe |
| cmd_data_i | input | 5 | Mask command data (fields per R3) |
| en_set_i | input | 1 | Set global enable |
| en_clr_i | input | 1 | Clear global enable |
| rd_req_i | input | 1 | Core read strobe (active high) |
| take_o | output | 1 | Request accepted (one-cycle pulse) |
| vec_o | output | 16 | Restart vector of accepted request |
| intr_ack_o | output | 1 | General request accepted; hold PC, run acknowledge |
| wake_o | output | 1 | Leave power-down |
| rd_o | output | 1 | Read strobe to memory or I/O |
| inta_o | output | 1 | Acknowledge strobe |

## Verification
On every cycle, the assertions check the following:
- an acceptance only follows an edge where evaluation was allowed;
- the enable is clear whenever an acceptance is reported;
- a wake pulse never appears without an acceptance made while idle;
- the vector is always one of the legal values, and it is zero for the general request;
- the read and acknowledge strobes are never both high.

Only the bench scenarios can show the rest:
- the order of priority;
- which mask bit blocks which level;
- that the edge latch persists and is cleared;
- that the non-maskable request needs its input to return low before it is accepted again;
- which read gets diverted after a general acceptance.

// File: rtl/prio_irq_pkg.sv
// Shared constants for the interrupt controller: source indices (index order
// is priority order), vector width, command field positions and vectors.
package prio_irq_pkg;
    localparam int NSRC    = 5;
    localparam int VEC_W   = 16;
    localparam int MASK_W  = 3;
    localparam int CMD_W   = 5;
    localparam int CMD_LD  = 3;   // load-mask field
    localparam int CMD_CLR = 4;   // clear-edge-latch field

    localparam int IDX_NMI  = 0;
    localparam int IDX_EDGE = 1;
    localparam int IDX_HI   = 2;
    localparam int IDX_LO   = 3;
    localparam int IDX_GEN  = 4;

    typedef enum logic [1:0] {ACK_IDLE, ACK_ARMED, ACK_ACTIVE} ack_st_e;

    // Fixed restart address for each source; the general request has none.
    function automatic logic [VEC_W-1:0] src_vector(input int idx);
        case (idx)
            IDX_NMI:  return VEC_W'(16'h0024);
            IDX_EDGE: return VEC_W'(16'h003C);
            IDX_HI:   return VEC_W'(16'h0034);
            IDX_LO:   return VEC_W'(16'h002C);
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/irq_src_cond.sv
// Conditions the two edge-qualified sources.
// The non-maskable source is ready on a rising edge while its level stays high.
// It re-arms only after the input returns low.
// The edge restart source is latched on a rising edge until it is serviced or cleared.
// Assumes synchronous inputs.
module irq_src_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic rq_edge_i,
    input  logic take_nmi,
    input  logic take_edge,
    input  logic clr_edge,
    output logic nmi_ready,
    output logic edge_pend
);
    logic nmi_prev, nmi_arm, edge_prev, edge_lat;
    logic nmi_rise, edge_rise;

    // Rising-edge detection against last cycle's levels.
    always_comb begin
        nmi_rise  = nmi_i & ~nmi_prev;
        edge_rise = rq_edge_i & ~edge_prev;
        nmi_ready = nmi_i & (nmi_arm | nmi_rise);
        edge_pend = edge_lat | edge_rise;
    end

    // Track previous levels, arm state and the edge latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev  <= 1'b0;
            nmi_arm   <= 1'b0;
            edge_prev <= 1'b0;
            edge_lat  <= 1'b0;
        end else begin
            nmi_prev  <= nmi_i;
            nmi_arm   <= nmi_ready & ~take_nmi;
            edge_prev <= rq_edge_i;
            edge_lat  <= edge_pend & ~take_edge & ~clr_edge;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Holds the per-level masks and the global enable.
// Decodes mask commands from the core.
// Any acceptance clears the enable, and this clear wins over a set in the same cycle.
module irq_mask_reg
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we_i,
    input  logic [CMD_W-1:0]  cmd_data_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              accept,
    output logic [MASK_W-1:0] mask,
    output logic              glob_en,
    output logic              clr_edge
);
    // Edge-latch clear is a same-cycle command decode.
    assign clr_edge = cmd_we_i & cmd_data_i[CMD_CLR];

    // Update masks and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '1;
            glob_en <= 1'b0;
        end else begin
            if (cmd_we_i && cmd_data_i[CMD_LD])
                mask <= cmd_data_i[MASK_W-1:0];
            if (accept || en_clr_i)
                glob_en <= 1'b0;
            else if (en_set_i)
                glob_en <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Fixed-priority one-hot grant: the lowest index wins.
module irq_prio_sel #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N-1:0] higher;

    assign higher[0] = 1'b0;
    assign grant[0]  = req[0];
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign higher[i] = higher[i-1] | req[i-1];
        assign grant[i]  = req[i] & ~higher[i];
    end
    assign any = higher[N-1] | req[N-1];
endmodule

// File: rtl/irq_ack_seq.sv
// After a general-request acceptance, diverts the core's next read strobe onto
// the acknowledge output until that strobe ends.
module irq_ack_seq
    import prio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rd_req_i,
    output logic rd_o,
    output logic inta_o
);
    ack_st_e st;
    logic    divert;

    // Route the strobe according to the state.
    always_comb begin
        divert = (st != ACK_IDLE);
        inta_o = rd_req_i & divert;
        rd_o   = rd_req_i & ~divert;
    end

    // Sequence: wait for the read, then for its end.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ACK_IDLE;
        else begin
            case (st)
                ACK_IDLE:   if (arm)       st <= ACK_ARMED;
                ACK_ARMED:  if (rd_req_i)  st <= ACK_ACTIVE;
                ACK_ACTIVE: if (!rd_req_i) st <= ACK_IDLE;
                default:                   st <= ACK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the interrupt controller.
// Qualifies the five sources, picks the winner at a decision edge and registers the result.
// Also drives wake and acknowledge routing.
// Assumes sample_i is one-cycle per instruction and that all inputs are synchronous.
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic             idle_i,
    input  logic             nmi_i,
    input  logic             rq_edge_i,
    input  logic             rq_hi_i,
    input  logic             rq_lo_i,
    input  logic             gen_irq_i,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_data_i,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    input  logic             rd_req_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             intr_ack_o,
    output logic             wake_o,
    output logic             rd_o,
    output logic             inta_o
);
    logic [MASK_W-1:0] mask;
    logic              glob_en, clr_edge, nmi_ready, edge_pend, any, accept;
    logic [NSRC-1:0]   req, grant;
    logic [VEC_W-1:0]  vec_n;

    irq_src_cond u_cond (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .rq_edge_i(rq_edge_i),
        .take_nmi(accept & grant[IDX_NMI]), .take_edge(accept & grant[IDX_EDGE]),
        .clr_edge(clr_edge), .nmi_ready(nmi_ready), .edge_pend(edge_pend)
    );

    irq_mask_reg u_mask (
        .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we_i), .cmd_data_i(cmd_data_i),
        .en_set_i(en_set_i), .en_clr_i(en_clr_i), .accept(accept),
        .mask(mask), .glob_en(glob_en), .clr_edge(clr_edge)
    );

    // Gate maskable sources by their mask bit and the global enable.
    always_comb begin
        req[IDX_NMI]  = nmi_ready;
        req[IDX_EDGE] = edge_pend & ~mask[2] & glob_en;
        req[IDX_HI]   = rq_hi_i   & ~mask[1] & glob_en;
        req[IDX_LO]   = rq_lo_i   & ~mask[0] & glob_en;
        req[IDX_GEN]  = gen_irq_i & glob_en;
    end

    irq_prio_sel #(.N(NSRC)) u_sel (.req(req), .grant(grant), .any(any));

    // Acceptance happens only at an allowed decision edge; the winner's vector is chosen here.
    always_comb begin
        accept = (sample_i | idle_i) & any;
        vec_n  = '0;
        for (int i = 0; i < NSRC; i++)
            if (grant[i]) vec_n = src_vector(i);
    end

    // Register the acceptance result for the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            vec_o      <= '0;
            intr_ack_o <= 1'b0;
            wake_o     <= 1'b0;
        end else begin
            take_o     <= accept;
            vec_o      <= accept ? vec_n : '0;
            intr_ack_o <= accept & grant[IDX_GEN];
            wake_o     <= accept & idle_i;
        end
    end

    irq_ack_seq u_ack (
        .clk(clk), .rst_n(rst_n), .arm(accept & grant[IDX_GEN]),
        .rd_req_i(rd_req_i), .rd_o(rd_o), .inta_o(inta_o)
    );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Cycle-level properties of the interrupt controller, bound to the top.
module prio_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sample_i,
    input logic        idle_i,
    input logic        take_o,
    input logic [15:0] vec_o,
    input logic        intr_ack_o,
    input logic        wake_o,
    input logic        rd_o,
    input logic        inta_o,
    input logic        glob_en
);
    // R4
    sample_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(sample_i || idle_i));
    // R5
    enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !glob_en);
    // R9
    wake_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (take_o && $past(idle_i)));
    // R2
    legal_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !intr_ack_o) |-> (vec_o == 16'h0024 || vec_o == 16'h003C ||
                                     vec_o == 16'h0034 || vec_o == 16'h002C));
    // R10
    ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack_o |-> (take_o && vec_o == 16'h0000));
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && inta_o));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .idle_i(idle_i),
    .take_o(take_o), .vec_o(vec_o), .intr_ack_o(intr_ack_o), .wake_o(wake_o),
    .rd_o(rd_o), .inta_o(inta_o), .glob_en(glob_en)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sample_i = 0, idle_i = 0, nmi_i = 0, rq_edge_i = 0, rq_hi_i = 0, rq_lo_i = 0;
    logic gen_irq_i = 0, cmd_we_i = 0, en_set_i = 0, en_clr_i = 0, rd_req_i = 0;
    logic [4:0]  cmd_data_i = '0;
    logic        take_o, intr_ack_o, wake_o, rd_o, inta_o;
    logic [15:0] vec_o;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl dut_i (.*);

    // Table fields: {mask[2:0], enable, req{nmi,edge,hi,lo,gen}, take, ack, vec[15:0]}
    localparam logic [26:0] TBL [11] = '{
        {3'b000, 1'b1, 5'b11111, 1'b1, 1'b0, 16'h0024},  // R2 nmi top
        {3'b000, 1'b1, 5'b01111, 1'b1, 1'b0, 16'h003C},  // R2
        {3'b000, 1'b1, 5'b00111, 1'b1, 1'b0, 16'h0034},  // R2
        {3'b000, 1'b1, 5'b00011, 1'b1, 1'b0, 16'h002C},  // R2
        {3'b000, 1'b1, 5'b00001, 1'b1, 1'b1, 16'h0000},  // R2 general last
        {3'b111, 1'b1, 5'b01111, 1'b1, 1'b1, 16'h0000},  // R3 all masked
        {3'b011, 1'b1, 5'b01110, 1'b1, 1'b0, 16'h003C},  // R3
        {3'b101, 1'b1, 5'b01110, 1'b1, 1'b0, 16'h0034},  // R3
        {3'b000, 1'b0, 5'b01111, 1'b0, 1'b0, 16'h0000},  // R5 disabled
        {3'b111, 1'b0, 5'b10000, 1'b1, 1'b0, 16'h0024},  // R1
        {3'b000, 1'b1, 5'b00000, 1'b0, 1'b0, 16'h0000}   // R4 nothing pending
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic step;  @(posedge clk); #1; endtask
    task automatic to_neg; @(negedge clk); endtask

    task automatic do_reset;
        to_neg;
        rst_n = 0; sample_i = 0; idle_i = 0; nmi_i = 0; rq_edge_i = 0; rq_hi_i = 0;
        rq_lo_i = 0; gen_irq_i = 0; cmd_we_i = 0; cmd_data_i = '0; en_set_i = 0;
        en_clr_i = 0; rd_req_i = 0;
        repeat (2) @(posedge clk);
        to_neg; rst_n = 1;
    endtask

    task automatic cfg(input logic [2:0] m, input logic en);
        cmd_we_i = 1; cmd_data_i = {2'b01, m}; en_set_i = en;
        step; to_neg;
        cmd_we_i = 0; cmd_data_i = '0; en_set_i = 0;
    endtask

    task automatic clear_req;
        nmi_i = 0; rq_edge_i = 0; rq_hi_i = 0; rq_lo_i = 0; gen_irq_i = 0; sample_i = 0;
    endtask

    initial begin
        // R2 R3 R5 R1 R4: table walk
        foreach (TBL[k]) begin
            do_reset;
            cfg(TBL[k][26:24], TBL[k][23]);
            {nmi_i, rq_edge_i, rq_hi_i, rq_lo_i, gen_irq_i} = TBL[k][22:18];
            sample_i = 1;
            step;
            chk($sformatf("R2 take row%0d", k), take_o, TBL[k][17]);
            chk($sformatf("R2 vec row%0d", k), vec_o, TBL[k][15:0]);
            chk($sformatf("R10 ack row%0d", k), intr_ack_o, TBL[k][16]);
            chk($sformatf("R9 no wake row%0d", k), wake_o, 1'b0);
            to_neg; clear_req;
        end

        // R6 reset state and masks set by reset
        do_reset;
        chk("R6 take", take_o, 0); chk("R6 inta", inta_o, 0);
        chk("R6 rd", rd_o, 0);     chk("R6 wake", wake_o, 0);
        en_set_i = 1; step; to_neg; en_set_i = 0;
        rq_edge_i = 1; rq_hi_i = 1; rq_lo_i = 1; sample_i = 1;
        step; chk("R6 masked after reset", take_o, 0);
        to_neg; clear_req;
        do_reset; cfg(3'b000, 1);
        sample_i = 1; step; chk("R6 edge latch cleared", take_o, 0);
        to_neg; clear_req;

        // R5 enable behaviour
        do_reset; cfg(3'b000, 1);
        rq_lo_i = 1; sample_i = 1;
        step; chk("R5 first take", take_o, 1); chk("R5 vec", vec_o, 16'h002C);
        to_neg; step; chk("R5 enable cleared", take_o, 0);
        to_neg; sample_i = 0; en_set_i = 1; step; to_neg; en_set_i = 0; sample_i = 1;
        step; chk("R5 re-enabled", take_o, 1);
        to_neg; sample_i = 0; en_set_i = 1; step; to_neg; en_set_i = 0; en_clr_i = 1;
        step; to_neg; en_clr_i = 0; sample_i = 1;
        step; chk("R5 disabled by clear", take_o, 0);
        to_neg; clear_req;

        // R7 edge latch persistence, service and command clear
        do_reset; cfg(3'b000, 1);
        rq_edge_i = 1; step; to_neg; rq_edge_i = 0; step; to_neg;
        sample_i = 1; step;
        chk("R7 latched", take_o, 1); chk("R7 vec", vec_o, 16'h003C);
        to_neg; sample_i = 0; en_set_i = 1; step; to_neg; en_set_i = 0; sample_i = 1;
        step; chk("R7 cleared by service", take_o, 0);
        to_neg; sample_i = 0;
        rq_edge_i = 1; step; to_neg; rq_edge_i = 0;
        cmd_we_i = 1; cmd_data_i = 5'b10000; step; to_neg; cmd_we_i = 0; cmd_data_i = '0;
        sample_i = 1; step; chk("R3 latch cleared by command", take_o, 0);
        to_neg; rq_lo_i = 1;
        step; chk("R3 masks kept without load", vec_o, 16'h002C);
        to_neg; clear_req;
        cfg(3'b100, 1);
        rq_edge_i = 1; step; to_neg; rq_edge_i = 0; sample_i = 1;
        step; chk("R7 masked stays pending", take_o, 0);
        to_neg; sample_i = 0; cfg(3'b000, 0); sample_i = 1;
        step; chk("R7 pending taken after unmask", vec_o, 16'h003C);
        to_neg; sample_i = 0; en_set_i = 1; rq_hi_i = 1; step; to_neg;
        en_set_i = 0; rq_hi_i = 0; sample_i = 1;
        step; chk("R7 level source not held", take_o, 0);
        to_neg; clear_req;

        // R8 non-maskable edge qualification
        do_reset;
        nmi_i = 1; sample_i = 1; step; chk("R8 first", vec_o, 16'h0024);
        to_neg; step; chk("R8 no repeat while high", take_o, 0);
        to_neg; nmi_i = 0; sample_i = 0; step; to_neg; nmi_i = 1; sample_i = 1;
        step; chk("R8 new edge", take_o, 1);
        to_neg; sample_i = 0; nmi_i = 0; step; to_neg;
        nmi_i = 1; step; to_neg; nmi_i = 0; sample_i = 1;
        step; chk("R8 dropped before sample", take_o, 0);
        to_neg; clear_req;

        // R4 R9 idle evaluation and wake
        do_reset; cfg(3'b000, 1);
        rq_hi_i = 1; step; chk("R4 no decision point", take_o, 0);
        to_neg; idle_i = 1; step;
        chk("R4 idle take", vec_o, 16'h0034); chk("R9 wake", wake_o, 1);
        to_neg; idle_i = 0; clear_req;

        // R10 acknowledge routing
        do_reset; cfg(3'b000, 1);
        gen_irq_i = 1; sample_i = 1; step;
        chk("R10 ack", intr_ack_o, 1); chk("R10 vec", vec_o, 0);
        to_neg; clear_req; rd_req_i = 1; #1;
        chk("R10 inta diverted", inta_o, 1); chk("R10 rd blocked", rd_o, 0);
        step; to_neg; rd_req_i = 0; #1; chk("R10 inta end", inta_o, 0);
        step; to_neg; rd_req_i = 1; #1;
        chk("R10 rd restored", rd_o, 1); chk("R10 inta quiet", inta_o, 0);
        to_neg; rd_req_i = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all R actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule